// File: doc/BRIEF.md
# XOR-Mapped Interleaved Bank Memory

This block is a word-addressed memory split across 2^n independent banks. Each access's bank is picked by a programmable hash. Every bit of the bank number is the parity of the address masked by one row of a 0/1 matrix. A power-of-two stride therefore spreads over all banks instead of landing on one. The word position inside the chosen bank is always the upper address bits. The mapping is one-to-one as long as the matrix columns for the low n address bits are linearly independent over GF(2).

Requests enter through one valid/ready port carrying an operation, an address and write data. Each request is steered to a small input queue in front of its bank. A bank serves one queued access and then stays busy for a fixed number of cycles. Read results from different banks can finish out of order, so they are collected in tagged slots of a shared reorder buffer and leave in acceptance order. Writes finish silently. A separate port replaces the matrix, and the block accepts a new matrix only while it has no work in flight.

Top module: `xim_bank_memory`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `cfg_reject` is 0, and the matrix is the identity on the low address bits, so the bank number equals `req_addr[n-1:0]`.
- R2: Bank-number bit j is the XOR of `req_addr & cfg_matrix[j*N +: N]`, where bit c of a row masks address bit c.
- R3: Inside its bank, an address is stored at word `req_addr[N-1:n]`. Two addresses with the same bank number and the same upper bits reach the same storage word.
- R4: A bank starts at most one access every `BANK_CYCLES` cycles (default 2). `req_ready` is 0 while the target bank's input queue (depth 2) is full.
- R5: Read data leaves on `rsp_valid`/`rsp_data` in the order the reads were accepted, even when a later read finishes first in another bank.
- R6: A write produces no response. A read accepted after a write to the same address returns the written data.
- R7: A matrix offered on `cfg_valid` while any request is queued or pending, or while a request is accepted in the same cycle, is refused. `cfg_reject` is 1 in the following cycle and the mapping in use does not change.
- R8: A matrix whose low n columns do not have rank n over GF(2) is refused with `cfg_reject`, even when the memory is idle.
- R9: With a matrix that folds the upper address bits into the bank bits, a stream of stride-2^n reads is accepted at one per cycle. With the identity matrix, the same stream is held to one per `BANK_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data present this cycle |
| rsp_data | output | DATA_W | Read data, in request order |
| cfg_valid | input | 1 | Offer a new mapping matrix |
| cfg_matrix | input | BANK_BITS*ADDR_W | Matrix, row j at bits [j*ADDR_W +: ADDR_W] |
| cfg_reject | output | 1 | Last offered matrix was refused |

## Verification
The whole address space is written under the identity mapping and read back. A different matrix is then loaded and addresses are read again. The words returned show which bank and offset each address now reaches, which separates a correct parity hash from plain low-bit selection and from a wrong offset. Reads to one busy bank mixed with reads to a free bank tell in-order delivery apart from completion order. A write followed at once by a read of the same address tests queue ordering inside a bank. A stride-4 stream timed under both matrices separates bank conflicts from spread traffic. Matrix offers are made while busy, in the same cycle as a request, with a singular low block, and while idle.

// File: rtl/xim_pkg.sv
// Package for the interleaved bank memory: the operation kind stored in
// the per-bank queues. Assumes nothing beyond a one-bit encoding.
package xim_pkg;
    typedef enum logic {
        XIM_READ  = 1'b0,
        XIM_WRITE = 1'b1
    } xim_op_e;
endpackage

// File: rtl/xim_bank_map.sv
// Address-to-bank hash. Each bank-number bit is the parity of the address
// masked by one matrix row, and a decoder turns the number into one-hot
// selects. The block also checks whether a candidate matrix has a full-rank
// low BANK_BITS x BANK_BITS block over GF(2).
// Assumes: BANK_BITS < ADDR_W; clk/rst_n are used only by the assertion.
module xim_bank_map #(
    parameter int ADDR_W    = 6,
    parameter int BANK_BITS = 2,
    localparam int BANKS    = 1 << BANK_BITS,
    localparam int MAT_W    = BANK_BITS * ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAT_W-1:0]     matrix,
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_BITS-1:0] bank_id,
    output logic [BANKS-1:0]     bank_sel,
    input  logic [MAT_W-1:0]     cand_matrix,
    output logic                 cand_ok
);
    // One parity tree per matrix row.
    for (genvar j = 0; j < BANK_BITS; j++) begin : g_row
        always_comb bank_id[j] = ^(matrix[j*ADDR_W +: ADDR_W] & addr);
    end

    // Decoder from the bank number to one-hot selects.
    always_comb bank_sel = BANKS'(1) << bank_id;

    // Gaussian elimination over GF(2) on the low square block.
    function automatic logic low_block_full_rank(input logic [MAT_W-1:0] m);
        logic [BANK_BITS-1:0] rows [BANK_BITS];
        logic [BANK_BITS-1:0] tmp;
        int   rnk;
        int   piv;
        logic found;
        for (int r = 0; r < BANK_BITS; r++)
            rows[r] = m[r*ADDR_W +: BANK_BITS];
        rnk = 0;
        for (int c = 0; c < BANK_BITS; c++) begin
            found = 1'b0;
            piv   = 0;
            for (int r = 0; r < BANK_BITS; r++)
                if (!found && r >= rnk && rows[r][c]) begin
                    found = 1'b1;
                    piv   = r;
                end
            if (found) begin
                tmp        = rows[piv];
                rows[piv]  = rows[rnk];
                rows[rnk]  = tmp;
                for (int r = 0; r < BANK_BITS; r++)
                    if (r != rnk && rows[r][c])
                        rows[r] = rows[r] ^ rows[rnk];
                rnk++;
            end
        end
        return rnk == BANK_BITS;
    endfunction

    // Rank test of the candidate matrix.
    always_comb cand_ok = low_block_full_rank(cand_matrix);

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(bank_sel));
endmodule

// File: rtl/xim_bank_unit.sv
// One memory bank together with its input queue. The head of the queue is
// served when the bank is free. A served access keeps the bank busy for
// BANK_CYCLES cycles. Reads present data and tag combinationally in the
// cycle they are served.
// Assumes: FIFO_DEPTH is a power of two; the caller never pushes when full.
module xim_bank_unit
    import xim_pkg::*;
#(
    parameter int OFF_W       = 4,
    parameter int DATA_W      = 16,
    parameter int TAG_W       = 2,
    parameter int FIFO_DEPTH  = 2,
    parameter int BANK_CYCLES = 2,
    localparam int WORDS      = 1 << OFF_W,
    localparam int PTR_W      = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1),
    localparam int BUSY_W     = $clog2(BANK_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  xim_op_e           push_op,
    input  logic [OFF_W-1:0]  push_off,
    input  logic [DATA_W-1:0] push_data,
    input  logic [TAG_W-1:0]  push_tag,
    output logic              full,
    output logic              empty,
    output logic              rd_en,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    xim_op_e           q_op   [FIFO_DEPTH];
    logic [OFF_W-1:0]  q_off  [FIFO_DEPTH];
    logic [DATA_W-1:0] q_data [FIFO_DEPTH];
    logic [TAG_W-1:0]  q_tag  [FIFO_DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic [BUSY_W-1:0] busy;
    logic [DATA_W-1:0] store [WORDS];
    logic              pop;

    // Queue status and the serve decision.
    always_comb begin
        full  = (count == CNT_W'(FIFO_DEPTH));
        empty = (count == '0);
        pop   = !empty && (busy == '0);
    end

    // Read data and tag of the head entry while it is served.
    always_comb begin
        rd_en   = pop && (q_op[rd_ptr] == XIM_READ);
        rd_tag  = q_tag[rd_ptr];
        rd_data = store[q_off[rd_ptr]];
    end

    // Queue pointers, occupancy and bank busy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            busy   <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
            if (pop)              busy <= BUSY_W'(BANK_CYCLES - 1);
            else if (busy != '0)  busy <= busy - 1'b1;
        end
    end

    // Queue entry storage.
    always_ff @(posedge clk) begin
        if (push) begin
            q_op[wr_ptr]   <= push_op;
            q_off[wr_ptr]  <= push_off;
            q_data[wr_ptr] <= push_data;
            q_tag[wr_ptr]  <= push_tag;
        end
    end

    // Bank storage write when a queued write is served.
    always_ff @(posedge clk) begin
        if (pop && q_op[rd_ptr] == XIM_WRITE)
            store[q_off[rd_ptr]] <= q_data[rd_ptr];
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    if (BANK_CYCLES > 1) begin : g_rate
        // R4
        bank_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pop |=> !pop);
    end
endmodule

// File: rtl/xim_reorder_buf.sv
// Reorder buffer for read results. A slot is allocated in acceptance order,
// any bank may fill any allocated slot, and the oldest slot is released
// as soon as its data is present.
// Assumes: DEPTH is a power of two; each port fills only allocated slots.
module xim_reorder_buf #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 4,
    parameter int NPORT   = 4,
    localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc,
    output logic [TAG_W-1:0]        alloc_tag,
    output logic                    full,
    output logic                    empty,
    input  logic [NPORT-1:0]        wr_en,
    input  logic [NPORT*TAG_W-1:0]  wr_tag,
    input  logic [NPORT*DATA_W-1:0] wr_data,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data
);
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [DEPTH-1:0]  slot_done;
    logic [TAG_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count;

    // Status and in-order output.
    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        empty     = (count == '0);
        alloc_tag = tail;
        rsp_valid = !empty && slot_done[head];
        rsp_data  = slot_data[head];
    end

    // Allocation, fill and release bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head      <= '0;
            tail      <= '0;
            count     <= '0;
            slot_done <= '0;
        end else begin
            if (alloc) begin
                slot_done[tail] <= 1'b0;
                tail            <= tail + 1'b1;
            end
            for (int p = 0; p < NPORT; p++)
                if (wr_en[p]) slot_done[wr_tag[p*TAG_W +: TAG_W]] <= 1'b1;
            if (rsp_valid) head <= head + 1'b1;
            count <= count + CNT_W'(alloc) - CNT_W'(rsp_valid);
        end
    end

    // Slot data capture from the banks.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++)
            if (wr_en[p]) slot_data[wr_tag[p*TAG_W +: TAG_W]] <= wr_data[p*DATA_W +: DATA_W];
    end

    // R5
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);

    for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
        // R5
        slot_fill_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[p] |-> (!empty && !slot_done[wr_tag[p*TAG_W +: TAG_W]]));
    end
endmodule

// File: rtl/xim_bank_memory.sv
// Top of the XOR-mapped interleaved bank memory. It hashes each request to
// a bank, queues it there, gathers read results in order and guards the
// loading of a new mapping matrix.
// Assumes: stored words are not moved when the matrix changes.
module xim_bank_memory
    import xim_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BANK_BITS   = 2,
    parameter int DATA_W      = 16,
    parameter int FIFO_DEPTH  = 2,
    parameter int ROB_DEPTH   = 4,
    parameter int BANK_CYCLES = 2,
    localparam int BANKS      = 1 << BANK_BITS,
    localparam int OFF_W      = ADDR_W - BANK_BITS,
    localparam int MAT_W      = BANK_BITS * ADDR_W,
    localparam int TAG_W      = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              cfg_valid,
    input  logic [MAT_W-1:0]  cfg_matrix,
    output logic              cfg_reject
);
    logic [MAT_W-1:0]        map_matrix;
    logic [BANK_BITS-1:0]    bank_id;
    logic [BANKS-1:0]        bank_sel;
    logic                    cand_ok;
    logic [BANKS-1:0]        bank_full, bank_empty, bank_rd;
    logic [BANKS*TAG_W-1:0]  bank_tag;
    logic [BANKS*DATA_W-1:0] bank_data;
    logic [TAG_W-1:0]        alloc_tag;
    logic                    rob_full, rob_empty;
    logic                    req_fire, idle, cfg_take;
    xim_op_e                 req_op;

    // Identity on the low address bits, used after reset.
    function automatic logic [MAT_W-1:0] identity_matrix();
        logic [MAT_W-1:0] m = '0;
        for (int j = 0; j < BANK_BITS; j++) m[j*ADDR_W + j] = 1'b1;
        return m;
    endfunction

    xim_bank_map #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)) map_i (
        .clk(clk), .rst_n(rst_n), .matrix(map_matrix), .addr(req_addr),
        .bank_id(bank_id), .bank_sel(bank_sel),
        .cand_matrix(cfg_matrix), .cand_ok(cand_ok)
    );

    // Request acceptance: target queue has room, reads also need a slot.
    always_comb begin
        req_op    = xim_op_e'(req_write);
        req_ready = !bank_full[bank_id] && (req_op == XIM_WRITE || !rob_full);
        req_fire  = req_valid && req_ready;
        idle      = (&bank_empty) && rob_empty && !req_fire;
        cfg_take  = cfg_valid && idle && cand_ok;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        xim_bank_unit #(
            .OFF_W(OFF_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
            .FIFO_DEPTH(FIFO_DEPTH), .BANK_CYCLES(BANK_CYCLES)
        ) bank_i (
            .clk(clk), .rst_n(rst_n),
            .push(req_fire && bank_sel[b]),
            .push_op(req_op),
            .push_off(req_addr[ADDR_W-1:BANK_BITS]),
            .push_data(req_wdata),
            .push_tag(alloc_tag),
            .full(bank_full[b]), .empty(bank_empty[b]),
            .rd_en(bank_rd[b]),
            .rd_tag(bank_tag[b*TAG_W +: TAG_W]),
            .rd_data(bank_data[b*DATA_W +: DATA_W])
        );
    end

    xim_reorder_buf #(.DATA_W(DATA_W), .DEPTH(ROB_DEPTH), .NPORT(BANKS)) rob_i (
        .clk(clk), .rst_n(rst_n),
        .alloc(req_fire && req_op == XIM_READ),
        .alloc_tag(alloc_tag), .full(rob_full), .empty(rob_empty),
        .wr_en(bank_rd), .wr_tag(bank_tag), .wr_data(bank_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Matrix register and refusal flag for the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_matrix <= identity_matrix();
            cfg_reject <= 1'b0;
        end else begin
            if (cfg_take) map_matrix <= cfg_matrix;
            cfg_reject <= cfg_valid && !cfg_take;
        end
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !((&bank_empty) && rob_empty && !req_fire)) |=> $stable(map_matrix));

    // R8
    cfg_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cand_ok) |=> cfg_reject);
endmodule

// File: tb/xim_bank_memory_tb_top.sv
// Directed bench for the interleaved bank memory. It keeps its own model of
// bank storage and its own hash, and checks responses against the model.
module xim_bank_memory_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int NB     = 2;
    localparam int DATA_W = 16;
    localparam int BANKS  = 1 << NB;
    localparam int WORDS  = 1 << (ADDR_W - NB);
    localparam int MAT_W  = NB * ADDR_W;

    localparam logic [MAT_W-1:0] M_IDENT = {6'b000010, 6'b000001};
    localparam logic [MAT_W-1:0] M_XOR   = {6'b101010, 6'b010101};
    localparam logic [MAT_W-1:0] M_SING  = {6'b000001, 6'b000001};

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic cfg_valid = 1'b0;
    logic [MAT_W-1:0] cfg_matrix = '0;
    logic cfg_reject;

    int n_checks = 0, n_fails = 0, cycles = 0;
    logic saw_stall = 1'b0;
    logic [MAT_W-1:0] tb_matrix = M_IDENT;
    logic [DATA_W-1:0] phys [BANKS][WORDS];
    logic [DATA_W-1:0] exp_q [$];
    string tag_q [$];

    xim_bank_memory dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_valid(cfg_valid),
        .cfg_matrix(cfg_matrix), .cfg_reject(cfg_reject)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input logic ok, input string tag, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    function automatic logic [NB-1:0] bhash(input logic [ADDR_W-1:0] a, input logic [MAT_W-1:0] m);
        logic [NB-1:0] y;
        for (int j = 0; j < NB; j++) y[j] = ^(m[j*ADDR_W +: ADDR_W] & a);
        return y;
    endfunction

    // Response monitor: each response must match the oldest expected read.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 response without read", rsp_data, 0);
            end else begin
                logic [DATA_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_data == e, t, rsp_data, e);
            end
        end
    end

    // Offer one request and hold it until it is taken.
    task automatic send(input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input string tag);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin
            saw_stall = 1'b1;
            @(negedge clk); #1;
        end
        if (wr) phys[bhash(a, tb_matrix)][a >> NB] = d;
        else begin
            exp_q.push_back(phys[bhash(a, tb_matrix)][a >> NB]);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic offer_cfg(input logic [MAT_W-1:0] m, input logic expect_rej, input string tag);
        cfg_valid = 1'b1; cfg_matrix = m;
        @(negedge clk);
        cfg_valid = 1'b0;
        check(cfg_reject == expect_rej, tag, cfg_reject, expect_rej);
        if (!expect_rej) tb_matrix = m;
        @(negedge clk);
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        check(cfg_reject == 1'b0, "R1 no reject after reset", cfg_reject, 0);
    endtask

    // R1 R3: fill every address under the identity and read a spread back.
    task automatic t_fill_readback();
        for (int a = 0; a < 64; a++) send(1'b1, ADDR_W'(a), 16'hA000 | 16'(a), "R3 fill");
        for (int a = 0; a < 64; a += 7) send(1'b0, ADDR_W'(a), '0, "R1 identity readback");
        drain();
    endtask

    // R6: a write followed at once by a read of the same address.
    task automatic t_raw();
        send(1'b1, 6'd9, 16'h1234, "R6 write");
        send(1'b0, 6'd9, '0, "R6 read after write");
        send(1'b1, 6'd9, 16'h5678, "R6 write");
        send(1'b1, 6'd9, 16'h9ABC, "R6 write");
        send(1'b0, 6'd9, '0, "R6 read after two writes");
        drain();
    endtask

    // R5: later reads to a free bank finish first but leave in order.
    task automatic t_order();
        send(1'b0, 6'd0, '0, "R5 order bank0 first");
        send(1'b0, 6'd4, '0, "R5 order bank0 second");
        send(1'b0, 6'd1, '0, "R5 order bank1");
        send(1'b0, 6'd2, '0, "R5 order bank2");
        drain();
    endtask

    // R7: offer made in the same cycle as a request, then while queued.
    task automatic t_cfg_busy();
        req_valid = 1'b1; req_write = 1'b0; req_addr = 6'd6; cfg_valid = 1'b1; cfg_matrix = M_XOR;
        #1;
        check(req_ready == 1'b1, "R7 request taken with offer", req_ready, 1);
        exp_q.push_back(phys[bhash(6'd6, tb_matrix)][6 >> NB]);
        tag_q.push_back("R7 read beside offer");
        @(negedge clk);
        req_valid = 1'b0; cfg_valid = 1'b0;
        check(cfg_reject == 1'b1, "R7 reject beside request", cfg_reject, 1);
        send(1'b0, 6'd20, '0, "R7 busy read");
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        check(cfg_reject == 1'b1, "R7 reject while pending", cfg_reject, 1);
        drain();
        send(1'b0, 6'd13, '0, "R7 mapping unchanged");
        send(1'b0, 6'd6, '0, "R7 mapping unchanged");
        drain();
    endtask

    // R8: singular low block refused while idle.
    task automatic t_cfg_singular();
        offer_cfg(M_SING, 1'b1, "R8 singular refused");
        send(1'b0, 6'd2, '0, "R8 mapping unchanged");
        drain();
    endtask

    // R2 R3: accept the XOR matrix and read words now reached by each address.
    task automatic t_remap();
        offer_cfg(M_XOR, 1'b0, "R2 matrix accepted");
        for (int a = 1; a < 64; a += 5) send(1'b0, ADDR_W'(a), '0, "R2 R3 hashed read");
        drain();
    endtask

    // R4 R9: stride-4 stream of eight reads under a given mapping.
    task automatic stream(output int used);
        int t0;
        t0 = cycles;
        for (int i = 0; i < 8; i++) send(1'b0, ADDR_W'(i * 4), '0, "R9 stride read");
        used = cycles - t0;
        drain();
    endtask

    task automatic t_stride();
        int c_xor, c_id;
        saw_stall = 1'b0;
        stream(c_xor);
        check(c_xor <= 9, "R9 spread stream rate", c_xor, 9);
        check(saw_stall == 1'b0, "R9 spread stream no stall", saw_stall, 0);
        offer_cfg(M_IDENT, 1'b0, "R9 identity accepted");
        saw_stall = 1'b0;
        stream(c_id);
        check(c_id >= 12, "R4 conflict stream rate", c_id, 12);
        check(saw_stall == 1'b1, "R4 ready low on full queue", saw_stall, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_readback();
        t_raw();
        t_order();
        t_cfg_busy();
        t_cfg_singular();
        t_remap();
        t_stride();
        summary();
    end
endmodule